// File: doc/BRIEF.md
# Twelve-Bit Operand Address Sequencer

This block resolves the operand of a 12-bit instruction. The instruction holds a 4-bit function code in bits 11..8, a 2-bit mode in bits 7..6 and a 6-bit field in bits 5..0. The function code and the mode together form the 6-bit opcode. The block takes the instruction word together with the address it was fetched from. It returns one of two things: an operand address, or an immediate value. It also returns the address of the next instruction, which is one or two words further on. When a form needs a word from memory, the block reads it through a single synchronous read port.

Instructions arrive on a valid/ready stream. A word is taken on a clock edge where `ins_valid` and `ins_ready` are both high. `ins_ready` is high only while the sequencer is idle, and the producer must hold its word steady until that edge. The result leaves as a one-cycle `res_done` strobe and has no back-pressure. The result registers keep their value until the next strobe. The memory port returns data one cycle after the cycle in which `mem_rd_en` is high.

Top module: `amseq_top`

## Requirements
- R1: After reset, `ins_ready` is 1, and both `res_done` and `mem_rd_en` are 0.
- R2: A function code with bit 3 clear and not 0000, with mode 00, is page-zero direct. Mode 00 with function bit 3 set has the same meaning. The result is the address equal to the zero-extended 6-bit field, and field 0 gives address 0. The next PC is PC+1.
- R3: Function bit 3 clear with mode 01 is page-zero indirect. The block reads the page-zero word at the field address, and all 12 bits of that word become the operand address. The next PC is PC+1.
- R4: Function bit 3 clear with mode 10 is forward relative. The address is PC plus the field, modulo 4096. The next PC is PC+1.
- R5: Function bit 3 clear with mode 11 is backward relative. The address is PC minus the field, modulo 4096. The next PC is PC+1.
- R6: Function bit 3 set with mode 01 is the memory form. The block reads the word at PC+1, and that word is the operand address. The next PC is PC+2, modulo 4096.
- R7: Function bit 3 set with mode 10 is the constant form. The word at PC+1 is returned as an immediate, with `res_is_imm` set to 1. The next PC is PC+2.
- R8: Function bit 3 set with mode 11 is the fixed-location form. The address is 0xFFF whatever the field holds. The form takes one word and no memory read, and the next PC is PC+1.
- R9: Function code 0000 is the no-address form. The immediate is the zero-extended low 6 bits, the mode is ignored, and the next PC is PC+1.
- R10: Forms without a memory read raise `res_done` in the first cycle after acceptance. Forms with a memory read issue exactly one read and raise `res_done` in the third cycle after acceptance.
- R11: `ins_ready` is 0 from acceptance until `res_done`. A word offered during that time is not taken and does not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Sequencer idle, able to take an instruction |
| ins_word | input | 12 | Instruction word |
| ins_pc | input | 12 | Address of the instruction word |
| mem_rd_en | output | 1 | Read request |
| mem_addr | output | 12 | Read address |
| mem_rdata | input | 12 | Read data, valid the cycle after the request |
| res_done | output | 1 | One-cycle result strobe |
| res_is_imm | output | 1 | 1: res_value is an immediate; 0: an address |
| res_value | output | 12 | Operand address or immediate |
| res_next_pc | output | 12 | Address of the next instruction |

## Verification
The bench tests the wrap cases. It uses forward relative near the top of memory, backward relative near zero, and a two-word form whose second word sits at 0x000. A design with the wrong arithmetic width or the wrong sign would return addresses that are off by 4096 or mirrored. Direct with field 0 and the fixed location with a nonzero field catch a design that treats zero as special or lets the field leak into 0xFFF. Read counts and strobe latency catch extra reads, a missed wait state, or a word that is accepted while busy and then overwrites the pending result.

// File: rtl/amseq_pkg.sv
`timescale 1ns/1ps
package amseq_pkg;
  typedef enum logic [2:0] {
    K_DIRECT,
    K_INDIRECT,
    K_FWD,
    K_BWD,
    K_MEMWORD,
    K_CONSTWORD,
    K_TOPLOC,
    K_SHORTIMM
  } oper_kind_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_READ,
    S_WAIT
  } seq_state_t;
endpackage

// File: rtl/amseq_decode.sv
`timescale 1ns/1ps
module amseq_decode
  import amseq_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 6
) (
  input  logic [WORD_W-1:0]  instr,
  output oper_kind_t         kind,
  output logic [FIELD_W-1:0] field
);
  localparam int FUNC_W = WORD_W - 2 - FIELD_W;

  logic [FUNC_W-1:0] func;
  logic [1:0]        mode;
  logic              alt;

  assign func  = instr[WORD_W-1 -: FUNC_W];
  assign mode  = instr[FIELD_W+1:FIELD_W];
  assign field = instr[FIELD_W-1:0];
  assign alt   = func[FUNC_W-1];

  always_comb begin
    if (func == '0) begin
      kind = K_SHORTIMM;
    end else begin
      unique case (mode)
        2'b00:   kind = K_DIRECT;
        2'b01:   kind = alt ? K_MEMWORD   : K_INDIRECT;
        2'b10:   kind = alt ? K_CONSTWORD : K_FWD;
        default: kind = alt ? K_TOPLOC    : K_BWD;
      endcase
    end
  end
endmodule

// File: rtl/amseq_addr.sv
`timescale 1ns/1ps
module amseq_addr #(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 6
) (
  input  logic [WORD_W-1:0]  pc,
  input  logic [FIELD_W-1:0] field,
  output logic [WORD_W-1:0]  zext_field,
  output logic [WORD_W-1:0]  fwd_addr,
  output logic [WORD_W-1:0]  bwd_addr,
  output logic [WORD_W-1:0]  top_addr,
  output logic [WORD_W-1:0]  pc_plus1,
  output logic [WORD_W-1:0]  pc_plus2
);
  localparam int PAD_W = WORD_W - FIELD_W;

  assign zext_field = {{PAD_W{1'b0}}, field};
  assign fwd_addr   = pc + zext_field;
  assign bwd_addr   = pc - zext_field;
  assign top_addr   = '1;
  assign pc_plus1   = pc + WORD_W'(1);
  assign pc_plus2   = pc + WORD_W'(2);
endmodule

// File: rtl/amseq_top.sv
`timescale 1ns/1ps
module amseq_top
  import amseq_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [WORD_W-1:0] ins_word,
  input  logic [WORD_W-1:0] ins_pc,
  output logic              mem_rd_en,
  output logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              res_done,
  output logic              res_is_imm,
  output logic [WORD_W-1:0] res_value,
  output logic [WORD_W-1:0] res_next_pc
);
  oper_kind_t         kind;
  logic [FIELD_W-1:0] field;
  logic [WORD_W-1:0]  zext_field, fwd_addr, bwd_addr, top_addr, pc_plus1, pc_plus2;
  seq_state_t         state;
  logic [WORD_W-1:0]  rd_addr_q, npc_q;
  logic               imm_q;
  logic               accept;

  amseq_decode #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_dec (
    .instr (ins_word),
    .kind  (kind),
    .field (field)
  );

  amseq_addr #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_addr (
    .pc         (ins_pc),
    .field      (field),
    .zext_field (zext_field),
    .fwd_addr   (fwd_addr),
    .bwd_addr   (bwd_addr),
    .top_addr   (top_addr),
    .pc_plus1   (pc_plus1),
    .pc_plus2   (pc_plus2)
  );

  assign ins_ready = (state == S_IDLE);
  assign accept    = ins_valid && ins_ready;
  assign mem_rd_en = (state == S_READ);
  assign mem_addr  = rd_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      rd_addr_q   <= '0;
      npc_q       <= '0;
      imm_q       <= 1'b0;
      res_done    <= 1'b0;
      res_is_imm  <= 1'b0;
      res_value   <= '0;
      res_next_pc <= '0;
    end else begin
      res_done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            unique case (kind)
              K_INDIRECT: begin
                rd_addr_q <= zext_field;
                npc_q     <= pc_plus1;
                imm_q     <= 1'b0;
                state     <= S_READ;
              end
              K_MEMWORD, K_CONSTWORD: begin
                rd_addr_q <= pc_plus1;
                npc_q     <= pc_plus2;
                imm_q     <= (kind == K_CONSTWORD);
                state     <= S_READ;
              end
              default: begin
                res_done    <= 1'b1;
                res_next_pc <= pc_plus1;
                res_is_imm  <= (kind == K_SHORTIMM);
                unique case (kind)
                  K_FWD:    res_value <= fwd_addr;
                  K_BWD:    res_value <= bwd_addr;
                  K_TOPLOC: res_value <= top_addr;
                  default:  res_value <= zext_field;
                endcase
              end
            endcase
          end
        end
        S_READ: state <= S_WAIT;
        default: begin
          res_done    <= 1'b1;
          res_value   <= mem_rdata;
          res_is_imm  <= imm_q;
          res_next_pc <= npc_q;
          state       <= S_IDLE;
        end
      endcase
    end
  end

  // R10: a read request is followed by a quiet wait cycle
  a_r10_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (!mem_rd_en && !res_done));

  // R11: results only appear once the sequencer is free again
  a_r11_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> ins_ready);

  a_r8_top_location: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_TOPLOC) |=> (res_done && res_value == '1 && !res_is_imm));

  a_r4_forward_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_FWD) |=>
      (res_done && res_value == $past(ins_pc + {{(WORD_W-FIELD_W){1'b0}}, ins_word[FIELD_W-1:0]})));

  a_r9_short_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_SHORTIMM) |=>
      (res_is_imm && res_value == $past({{(WORD_W-FIELD_W){1'b0}}, ins_word[FIELD_W-1:0]})));

  a_r6_second_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (kind == K_MEMWORD || kind == K_CONSTWORD)) |=>
      (mem_rd_en && mem_addr == $past(ins_pc + WORD_W'(1))));
endmodule

// File: tb/amseq_top_test.sv
`timescale 1ns/1ps
module amseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [11:0] ins_word = '0;
  logic [11:0] ins_pc = '0;
  logic        mem_rd_en;
  logic [11:0] mem_addr;
  logic [11:0] mem_rdata = '0;
  logic        res_done, res_is_imm;
  logic [11:0] res_value, res_next_pc;

  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;

  always #2 clk = ~clk;

  amseq_top uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .ins_pc(ins_pc), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .res_done(res_done), .res_is_imm(res_is_imm),
    .res_value(res_value), .res_next_pc(res_next_pc)
  );

  function automatic logic [11:0] memf(input logic [11:0] a);
    return a * 12'd7 + 12'h123;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= memf(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [11:0] w, input logic [11:0] pc,
                          input bit e_imm, input logic [11:0] e_val, input logic [11:0] e_npc,
                          input int e_lat, input int e_rd);
    int lat;
    int base;
    @(negedge clk);
    ins_word = w; ins_pc = pc; ins_valid = 1'b1; base = rd_cnt;
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    lat = 1;
    while (!res_done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(lat == e_lat, tag, "latency", lat, e_lat);
    check(res_is_imm == e_imm, tag, "is_imm", res_is_imm, e_imm);
    check(res_value == e_val, tag, "value", res_value, e_val);
    check(res_next_pc == e_npc, tag, "next_pc", res_next_pc, e_npc);
    check(rd_cnt - base == e_rd, tag, "reads", rd_cnt - base, e_rd);
  endtask

  task automatic test_reset();
    check(ins_ready == 1'b1, "R1", "ready", ins_ready, 1);
    check(res_done == 1'b0, "R1", "done", res_done, 0);
    check(mem_rd_en == 1'b0, "R1", "rd_en", mem_rd_en, 0);
  endtask

  task automatic test_direct();
    run_case("R2", {4'h2, 2'b00, 6'd0}, 12'h100, 1'b0, 12'h000, 12'h101, 1, 0);
    run_case("R2", {4'h2, 2'b00, 6'd63}, 12'h100, 1'b0, 12'h03F, 12'h101, 1, 0);
    run_case("R2", {4'hA, 2'b00, 6'd17}, 12'h0FF, 1'b0, 12'h011, 12'h100, 1, 0);
  endtask

  task automatic test_indirect();
    run_case("R3", {4'h3, 2'b01, 6'd5}, 12'h200, 1'b0, memf(12'h005), 12'h201, 3, 1);
    run_case("R3", {4'h3, 2'b01, 6'd0}, 12'hFFF, 1'b0, memf(12'h000), 12'h000, 3, 1);
  endtask

  task automatic test_relative();
    run_case("R4", {4'h4, 2'b10, 6'h20}, 12'hFF0, 1'b0, 12'h010, 12'hFF1, 1, 0);
    run_case("R4", {4'h4, 2'b10, 6'h00}, 12'h100, 1'b0, 12'h100, 12'h101, 1, 0);
    run_case("R5", {4'h5, 2'b11, 6'h10}, 12'h005, 1'b0, 12'hFF5, 12'h006, 1, 0);
    run_case("R5", {4'h5, 2'b11, 6'h3F}, 12'h800, 1'b0, 12'h7C1, 12'h801, 1, 0);
  endtask

  task automatic test_two_word();
    run_case("R6", {4'hB, 2'b01, 6'h2C}, 12'h300, 1'b0, memf(12'h301), 12'h302, 3, 1);
    run_case("R6", {4'hB, 2'b01, 6'h00}, 12'hFFF, 1'b0, memf(12'h000), 12'h001, 3, 1);
    run_case("R7", {4'hC, 2'b10, 6'h01}, 12'h040, 1'b1, memf(12'h041), 12'h042, 3, 1);
    run_case("R7", {4'hC, 2'b10, 6'h3F}, 12'hFFE, 1'b1, memf(12'hFFF), 12'h000, 3, 1);
  endtask

  task automatic test_toploc();
    run_case("R8", {4'hD, 2'b11, 6'h15}, 12'h777, 1'b0, 12'hFFF, 12'h778, 1, 0);
    run_case("R8", {4'hF, 2'b11, 6'h00}, 12'hFFF, 1'b0, 12'hFFF, 12'h000, 1, 0);
  endtask

  task automatic test_short_imm();
    run_case("R9", {4'h0, 2'b11, 6'h2A}, 12'h010, 1'b1, 12'h02A, 12'h011, 1, 0);
    run_case("R9", {4'h0, 2'b01, 6'h3F}, 12'h020, 1'b1, 12'h03F, 12'h021, 1, 0);
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    ins_word = {4'h3, 2'b01, 6'd7}; ins_pc = 12'h010; ins_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ins_word = {4'h2, 2'b00, 6'd9}; ins_pc = 12'h500;
    check(ins_ready == 1'b0, "R11", "ready busy1", ins_ready, 0);
    @(negedge clk);
    check(ins_ready == 1'b0, "R11", "ready busy2", ins_ready, 0);
    check(res_done == 1'b0, "R10", "early done", res_done, 0);
    @(negedge clk);
    check(res_done == 1'b1, "R11", "first done", res_done, 1);
    check(res_value == memf(12'h007), "R11", "first value", res_value, memf(12'h007));
    check(res_next_pc == 12'h011, "R11", "first npc", res_next_pc, 12'h011);
    @(negedge clk);
    ins_valid = 1'b0;
    check(res_done == 1'b1, "R11", "second done", res_done, 1);
    check(res_value == 12'h009, "R11", "second value", res_value, 12'h009);
    check(res_next_pc == 12'h501, "R11", "second npc", res_next_pc, 12'h501);
    @(negedge clk);
    check(res_done == 1'b0, "R10", "single pulse", res_done, 0);
  endtask

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_direct();
    test_indirect();
    test_relative();
    test_two_word();
    test_toploc();
    test_short_imm();
    test_backpressure();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule